// File: doc/BRIEF.md
# Shared SPI Flash Line Arbiter

This block lets several independent flash command engines share a single set of serial flash lines. Each engine asks for the bus by raising its own request line. The arbiter picks one engine and answers with a one-cycle acknowledge pulse. It then steers that engine's chip-select, clock and data-out values onto the flash pins until the engine lowers its request. A second one-cycle pulse on the same acknowledge line confirms the release.

While no engine owns the bus, the pins rest at their inactive levels. Serial data returning from the flash is copied to every engine without change. The four engines are ordered by index: 0 issues write-enable commands, 1 reads status, 2 erases and 3 programs pages. This order is also the priority order.

Top module: `spi_flash_arbiter`

## Requirements
- R1: While the arbiter is idle, a high request on any client produces a grant pulse on that client's acknowledge bit, visible in the cycle after the clock edge that sampled the request.
- R2: When several clients request in the same idle cycle, the lowest index wins. The priority is index 0 (write enable), then 1 (status read), then 2 (erase), then 3 (page program).
- R3: Every acknowledge pulse lasts exactly one cycle, and at most one acknowledge bit is high at any time.
- R4: While the owner keeps its request high, no other client receives an acknowledge, whatever the other requests do.
- R5: When the owner lowers its request, that client's acknowledge bit pulses once, in the cycle after the edge that sees the low request.
- R6: The release pulse cycle is followed by one cycle in which the arbiter takes no request. The earliest next grant pulse appears three cycles after the release pulse.
- R7: Whenever no client owns the bus, including during and after reset, the pins sit at chip select 1, clock 0 and data out 1.
- R8: From the cycle after the grant pulse until the cycle of the release pulse, the pins carry the owner's chip select, clock and data-out values, delayed by one register stage. The lines of clients that are not granted have no effect on the pins.
- R9: The incoming serial data line reaches every client's data-in output unchanged, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_CLIENTS | Per-client bus request level |
| ack_o | output | N_CLIENTS | Per-client grant/release done pulse |
| cli_cs_i | input | N_CLIENTS | Per-client chip-select value |
| cli_sclk_i | input | N_CLIENTS | Per-client serial clock value |
| cli_mosi_i | input | N_CLIENTS | Per-client serial data-out value |
| miso_i | input | 1 | Serial data returned by the flash |
| cli_miso_o | output | N_CLIENTS | Returned serial data, copied to each client |
| flash_cs_o | output | 1 | Chip select pin |
| flash_sclk_o | output | 1 | Serial clock pin |
| flash_mosi_o | output | 1 | Serial data-out pin |

## Verification
The hardest cases to reach are the ones where lower-priority requests stay pending while a higher-priority owner holds the bus and then releases it. Those are the moments that show whether the arbiter pre-empts the owner or skips its cool-down cycle. The stimulus sweeps all fifteen non-empty request patterns. In each pattern every client keeps its request up until it has been served, so the waiting requests are still present through the hold phase, the release pulse and the idle cycle. During each hold, the lines of the clients that are not granted are driven opposite to the owner's, so any leak onto the pins shows up.

// File: rtl/spi_arb_pkg.sv
package spi_arb_pkg;
  typedef enum logic [2:0] {
    ARB_IDLE,
    ARB_GRANT_ACK,
    ARB_HOLD,
    ARB_REL_ACK,
    ARB_COOL
  } arb_state_e;

  localparam logic PIN_CS_IDLE   = 1'b1;
  localparam logic PIN_SCLK_IDLE = 1'b0;
  localparam logic PIN_MOSI_IDLE = 1'b1;
endpackage

// File: rtl/spi_arb_prio.sv
module spi_arb_prio #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  // Lowest index wins: scan downward so the last match is the smallest.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/spi_arb_ctrl.sv
module spi_arb_ctrl
  import spi_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic          hit_i,
  input  logic [IW-1:0] pick_i,
  output logic [IW-1:0] owner_o,
  output logic          route_o,
  output logic [N-1:0]  ack_o
);
  localparam logic [N-1:0] ONE = N'(1);

  arb_state_e    state_q;
  logic [IW-1:0] owner_q;
  logic [N-1:0]  ack_q;
  logic          route_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_IDLE;
      owner_q <= '0;
      ack_q   <= '0;
      route_q <= 1'b0;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          ack_q <= '0;
          if (hit_i) begin
            owner_q <= pick_i;
            ack_q   <= ONE << pick_i;
            route_q <= 1'b1;
            state_q <= ARB_GRANT_ACK;
          end
        end
        ARB_GRANT_ACK: begin
          ack_q   <= '0;
          state_q <= ARB_HOLD;
        end
        ARB_HOLD: begin
          if (!req_i[owner_q]) begin
            ack_q   <= ONE << owner_q;
            route_q <= 1'b0;
            state_q <= ARB_REL_ACK;
          end
        end
        ARB_REL_ACK: begin
          ack_q   <= '0;
          state_q <= ARB_COOL;
        end
        ARB_COOL: begin
          state_q <= ARB_IDLE;
        end
        default: begin
          ack_q   <= '0;
          route_q <= 1'b0;
          state_q <= ARB_IDLE;
        end
      endcase
    end
  end

  assign owner_o = owner_q;
  assign route_o = route_q;
  assign ack_o   = ack_q;

  // R3: an acknowledge never names two clients
  a_r3_onehot_ack: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_q));

  // R3: each pulse lasts a single cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (ack_q != '0) |=> (ack_q == '0));

  // R8: the owner cannot change while the bus is routed
  a_r8_owner_stable: assert property (@(posedge clk) disable iff (rst)
    route_q |=> (!route_q || $stable(owner_q)));
endmodule

// File: rtl/spi_arb_pinmux.sv
module spi_arb_pinmux
  import spi_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          route_i,
  input  logic [IW-1:0] owner_i,
  input  logic [N-1:0]  cs_i,
  input  logic [N-1:0]  sclk_i,
  input  logic [N-1:0]  mosi_i,
  output logic          cs_o,
  output logic          sclk_o,
  output logic          mosi_o
);
  logic cs_sel, sclk_sel, mosi_sel;

  always_comb begin
    cs_sel   = PIN_CS_IDLE;
    sclk_sel = PIN_SCLK_IDLE;
    mosi_sel = PIN_MOSI_IDLE;
    if (route_i) begin
      cs_sel   = cs_i[owner_i];
      sclk_sel = sclk_i[owner_i];
      mosi_sel = mosi_i[owner_i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_o   <= PIN_CS_IDLE;
      sclk_o <= PIN_SCLK_IDLE;
      mosi_o <= PIN_MOSI_IDLE;
    end else begin
      cs_o   <= cs_sel;
      sclk_o <= sclk_sel;
      mosi_o <= mosi_sel;
    end
  end
endmodule

// File: rtl/spi_flash_arbiter.sv
module spi_flash_arbiter
  import spi_arb_pkg::*;
#(
  parameter int N_CLIENTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_CLIENTS-1:0] req_i,
  output logic [N_CLIENTS-1:0] ack_o,
  input  logic [N_CLIENTS-1:0] cli_cs_i,
  input  logic [N_CLIENTS-1:0] cli_sclk_i,
  input  logic [N_CLIENTS-1:0] cli_mosi_i,
  input  logic                 miso_i,
  output logic [N_CLIENTS-1:0] cli_miso_o,
  output logic                 flash_cs_o,
  output logic                 flash_sclk_o,
  output logic                 flash_mosi_o
);
  localparam int IW = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1;
  localparam logic [N_CLIENTS-1:0] ONE = N_CLIENTS'(1);

  logic          hit;
  logic [IW-1:0] pick;
  logic [IW-1:0] owner;
  logic          route;

  spi_arb_prio #(.N(N_CLIENTS), .IW(IW)) u_prio (
    .req_i (req_i),
    .hit_o (hit),
    .idx_o (pick)
  );

  spi_arb_ctrl #(.N(N_CLIENTS), .IW(IW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .hit_i   (hit),
    .pick_i  (pick),
    .owner_o (owner),
    .route_o (route),
    .ack_o   (ack_o)
  );

  spi_arb_pinmux #(.N(N_CLIENTS), .IW(IW)) u_pins (
    .clk     (clk),
    .rst     (rst),
    .route_i (route),
    .owner_i (owner),
    .cs_i    (cli_cs_i),
    .sclk_i  (cli_sclk_i),
    .mosi_i  (cli_mosi_i),
    .cs_o    (flash_cs_o),
    .sclk_o  (flash_sclk_o),
    .mosi_o  (flash_mosi_o)
  );

  // R9: returned serial data goes to every client
  for (genvar g = 0; g < N_CLIENTS; g++) begin : g_miso_fan
    assign cli_miso_o[g] = miso_i;
  end

  // R4: a held grant keeps every acknowledge quiet
  a_r4_no_preempt: assert property (@(posedge clk) disable iff (rst)
    (route && req_i[owner]) |=> (ack_o == '0));

  // R5: a dropped request earns the owner its release pulse
  a_r5_release_ack: assert property (@(posedge clk) disable iff (rst)
    (route && !req_i[owner] && ack_o == '0) |=> (ack_o == (ONE << owner)));

  // R6: two quiet cycles follow a release pulse
  a_r6_cool_down: assert property (@(posedge clk) disable iff (rst)
    (ack_o != '0 && !route) |=> (ack_o == '0) ##1 (ack_o == '0));

  // R7: the pins fall to their inactive levels after a release
  a_r7_idle_pins: assert property (@(posedge clk) disable iff (rst)
    (ack_o != '0 && !route) |=> (flash_cs_o && !flash_sclk_o && flash_mosi_o));
endmodule

// File: tb/tb_spi_flash_arbiter.sv
module tb_spi_flash_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] cs = '1;
  logic [N-1:0] sc = '0;
  logic [N-1:0] mo = '1;
  logic         miso = 1'b0;
  logic [N-1:0] ack;
  logic [N-1:0] fan;
  logic         pcs, psc, pmo;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spi_flash_arbiter #(.N_CLIENTS(N)) dut (
    .clk (clk), .rst (rst), .req_i (req), .ack_o (ack),
    .cli_cs_i (cs), .cli_sclk_i (sc), .cli_mosi_i (mo),
    .miso_i (miso), .cli_miso_o (fan),
    .flash_cs_o (pcs), .flash_sclk_o (psc), .flash_mosi_o (pmo)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int lowest(input int p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic int pins();
    return {29'd0, pcs, psc, pmo};
  endfunction

  task automatic serve(input int pat);
    int rem = pat;
    req = N'(pat);
    while (rem != 0) begin
      int  w = lowest(rem);
      logic v1 = logic'((pat + w) & 1);
      logic v2 = logic'(((pat >> 1) + w) & 1);
      logic [N-1:0] m = N'(1) << w;
      cs = ~m;
      sc = v1 ? m : ~m;
      mo = v2 ? m : ~m;
      step();
      chk("R1/R2", "grant ack", ack, m);
      chk("R7", "pins idle at grant", pins(), 3'b101);
      step();
      chk("R3", "ack single pulse", ack, 0);
      chk("R8", "pins follow owner", pins(), {1'b0, v1, v2});
      sc[w] = ~v1;
      step();
      chk("R8", "pins track owner clock", pins(), {1'b0, ~v1, v2});
      for (int k = 0; k < 3; k++) begin
        step();
        chk("R4", "no pre-emption", ack, 0);
      end
      req[w] = 1'b0;
      rem = rem & ~(1 << w);
      step();
      chk("R5", "release ack", ack, m);
      step();
      chk("R3", "release pulse ends", ack, 0);
      chk("R7", "pins idle after release", pins(), 3'b101);
      step();
      chk("R6", "cool-down cycle quiet", ack, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    req = 4'b1111;
    repeat (3) step();
    chk("R7", "ack during reset", ack, 0);
    chk("R7", "pins during reset", pins(), 3'b101);
    req = '0;
    rst = 1'b0;
    step();
    chk("R7", "pins after reset", pins(), 3'b101);
    chk("R3", "ack after reset", ack, 0);

    miso = 1'b0; #1;
    chk("R9", "data fan-out low", fan, 0);
    miso = 1'b1; #1;
    chk("R9", "data fan-out high", fan, 4'hF);
    @(negedge clk);

    for (int p = 1; p < (1 << N); p++) begin
      serve(p);
      req = '0;
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule